// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog counter that advances on a low-rate tick enable and times out after a selectable number of ticks. Software sees one control/status byte through a simple write/read port. On time-out the block does one of four things: nothing, raise an interrupt, pulse a system reset, or raise an interrupt first and reset on the following time-out if the interrupt has not been serviced. A kick input restarts the count. An interrupt-acknowledge input clears the pending flag.

Two mechanisms protect the configuration. The time-out select can only change, and the reset enable can only be cleared, inside a short unlock window. Software opens that window with a dedicated write, and hardware closes it four clock cycles later. An external reset-flag input pins the reset enable high. A fuse-style input forces system-reset behaviour whatever the control byte holds.

Top module: `wdt_guard`

## Requirements
- R1: Reset clears the control byte to 0x00 with no pending flag, no interrupt and no reset pulse. With the fuse input at 1 the watchdog is then stopped, so no time-out occurs however many ticks arrive.
- R2: The control byte holds the pending flag in bit 7, interrupt-enable in bit 6, unlock in bit 4 and reset-enable in bit 3. The 4-bit time-out select is {bit 5, bits 2..0}, with bit 5 as its MSB. Software cannot write bit 7.
- R3: With the fuse input at 1, {reset-enable, interrupt-enable} selects the mode: 00 stopped, 01 interrupt, 10 reset, 11 interrupt-then-reset.
- R4: With the fuse input at 0 the block is in reset mode whatever the byte holds. Each time-out pulses the reset output and never sets the pending flag.
- R5: A time-out happens after 2^(BASE_LOG2+s) ticks, where s is the select code. Codes above MAX_CODE (default 9) behave as MAX_CODE. Cycles with the tick enable low do not count.
- R6: A kick clears the counter. A time-out restarts it from zero. The reset output is high for exactly one cycle per reset time-out.
- R7: A write with unlock=1 and reset-enable=1, made while the window is closed, opens the window. The unlock bit then reads 1 for four cycles and is cleared by hardware. A write made while the bit is 1 loads the select code and reset-enable from the written byte and closes the window.
- R8: A write made while the window is closed cannot clear reset-enable or change the select code. Such a write can set reset-enable and always loads interrupt-enable.
- R9: While the reset-flag input is 1, reset-enable reads 1 and cannot be cleared. It stays 1 after the input falls, until it is cleared through the window.
- R10: In interrupt mode a time-out sets the pending flag, and the interrupt output equals flag AND interrupt-enable. An acknowledge clears the flag and leaves interrupt-enable set.
- R11: In interrupt-then-reset mode a time-out with no flag pending sets the flag and gives no reset. An acknowledge clears both the flag and interrupt-enable, which moves the block into reset mode. A time-out that finds the flag still pending pulses the reset output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Watchdog tick enable; the counter advances on cycles where it is 1 |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Current control/status byte |
| kick | input | 1 | Restart the counter |
| irq_ack | input | 1 | Interrupt acknowledge |
| rst_flag | input | 1 | External reset flag; pins reset-enable |
| fuse_on_n | input | 1 | 0 forces reset mode (always-on fuse programmed) |
| irq | output | 1 | Interrupt request |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
A wrong counter limit or a wrong select decode appears only as a time-out that arrives early or late. The bench therefore counts edges from a kick to the event and requires the exact figure, including ticks withheld by the enable. A stuck unlock window shows at once on bit 4 of the read port, and a leaky window shows as a select code or reset-enable that changes after a write that should have been refused. Mode errors in the combined interrupt-then-reset sequence show one period late, as a reset where a flag was due or the reverse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WM_STOP      = 2'd0,
        WM_IRQ       = 2'd1,
        WM_RESET     = 2'd2,
        WM_IRQ_RESET = 2'd3
    } wdt_mode_e;

    typedef struct packed {
        logic       flag;
        logic       irq_en;
        logic       unlock;
        logic       rst_en;
        logic [3:0] sel;
    } wdt_cfg_t;

    function automatic logic [7:0] cfg_to_byte(input wdt_cfg_t c, input logic pin_re);
        return {c.flag, c.irq_en, c.sel[3], c.unlock, c.rst_en | pin_re, c.sel[2:0]};
    endfunction

    function automatic wdt_cfg_t byte_to_cfg(input logic [7:0] b);
        wdt_cfg_t c;
        c.flag   = b[7];
        c.irq_en = b[6];
        c.unlock = b[4];
        c.rst_en = b[3];
        c.sel    = {b[5], b[2:0]};
        return c;
    endfunction

    function automatic wdt_mode_e pick_mode(input logic fuse_n, input logic re, input logic ie);
        if (!fuse_n) return WM_RESET;
        case ({re, ie})
            2'b01:   return WM_IRQ;
            2'b10:   return WM_RESET;
            2'b11:   return WM_IRQ_RESET;
            default: return WM_STOP;
        endcase
    endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  logic [7:0] wr_data,
    input  logic     rst_flag,
    input  logic     irq_ack,
    input  logic     ack_drops_ie,
    input  logic     set_flag,
    output wdt_cfg_t cfg
);
    localparam int WIN_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

    wdt_cfg_t         cfg_q, cfg_d, wr_c;
    logic [WIN_W-1:0] win_q, win_d;

    assign wr_c = byte_to_cfg(wr_data);
    assign cfg  = cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        win_d = win_q;
        if (wr_en) begin
            cfg_d.irq_en = wr_c.irq_en;
            if (cfg_q.unlock) begin
                cfg_d.sel    = wr_c.sel;
                cfg_d.rst_en = wr_c.rst_en;
                cfg_d.unlock = 1'b0;
            end else begin
                cfg_d.rst_en = cfg_q.rst_en | wr_c.rst_en;
                if (wr_c.unlock && wr_c.rst_en) begin
                    cfg_d.unlock = 1'b1;
                    win_d        = WIN_W'(WIN_CYC - 1);
                end
            end
        end else if (cfg_q.unlock) begin
            if (win_q == '0) cfg_d.unlock = 1'b0;
            else             win_d = win_q - 1'b1;
        end
        if (irq_ack) begin
            cfg_d.flag = 1'b0;
            if (ack_drops_ie) cfg_d.irq_en = 1'b0;
        end else if (set_flag) begin
            cfg_d.flag = 1'b1;
        end
        if (rst_flag) cfg_d.rst_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            win_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/wdt_tick_cnt.sv
module wdt_tick_cnt #(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  logic       kick,
    input  logic [3:0] sel,
    output logic       expire
);
    localparam int CNT_W = BASE_LOG2 + MAX_CODE + 1;

    logic [CNT_W-1:0] cnt_q, last;
    logic [3:0]       eff;

    always_comb begin
        eff  = (sel > 4'(MAX_CODE)) ? 4'(MAX_CODE) : sel;
        last = (CNT_W'(1) << (BASE_LOG2 + int'(eff))) - CNT_W'(1);
    end

    assign expire = run && tick && !kick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || !run || kick) cnt_q <= '0;
        else if (expire)         cnt_q <= '0;
        else if (tick)           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
    import wdt_pkg::*;
(
    input  wdt_mode_e mode,
    input  logic      expire,
    input  logic      flag,
    output logic      set_flag,
    output logic      fire_rst
);
    always_comb begin
        set_flag = 1'b0;
        fire_rst = 1'b0;
        case (mode)
            WM_IRQ:       set_flag = expire;
            WM_RESET:     fire_rst = expire;
            WM_IRQ_RESET: begin
                if (flag) fire_rst = expire;
                else      set_flag = expire;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int MAX_CODE  = 9,
    parameter int WIN_CYC   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kick,
    input  logic       irq_ack,
    input  logic       rst_flag,
    input  logic       fuse_on_n,
    output logic       irq,
    output logic       sys_rst_pulse
);
    wdt_cfg_t  cfg;
    wdt_mode_e mode;
    logic      expire, set_flag, fire_rst, pulse_q;

    assign mode = pick_mode(fuse_on_n, cfg.rst_en | rst_flag, cfg.irq_en);

    wdt_cfg_reg #(.WIN_CYC(WIN_CYC)) cfg_i (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rst_flag     (rst_flag),
        .irq_ack      (irq_ack),
        .ack_drops_ie (mode == WM_IRQ_RESET),
        .set_flag     (set_flag),
        .cfg          (cfg)
    );

    wdt_tick_cnt #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .run    (mode != WM_STOP),
        .tick   (tick_en),
        .kick   (kick),
        .sel    (cfg.sel),
        .expire (expire)
    );

    wdt_action act_i (
        .mode     (mode),
        .expire   (expire),
        .flag     (cfg.flag),
        .set_flag (set_flag),
        .fire_rst (fire_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= fire_rst;
    end

    assign sys_rst_pulse = pulse_q;
    assign irq           = cfg.flag & cfg.irq_en;
    assign rd_data       = cfg_to_byte(cfg, rst_flag);
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rd_data,
    input logic       sys_rst_pulse,
    input logic       irq_ack,
    input logic       rst_flag,
    input logic       fuse_on_n
);
    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    // R7
    window_len_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_data[4] && $past(rd_data[4], 1) && $past(rd_data[4], 2)
          && $past(rd_data[4], 3) && $past(rd_data[4], 4)));

    // R8
    sel_locked_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_data[4]) |-> ({rd_data[5], rd_data[2:0]} == $past({rd_data[5], rd_data[2:0]})));

    // R9
    pin_holds_re_chk: assert property (@(posedge clk) disable iff (rst)
        rst_flag |=> rd_data[3]);

    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !rd_data[7]);

    // R4
    fuse_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!fuse_on_n && $past(!fuse_on_n)) |-> !$rose(rd_data[7]));
endmodule

bind wdt_guard wdt_guard_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .rd_data       (rd_data),
    .sys_rst_pulse (sys_rst_pulse),
    .irq_ack       (irq_ack),
    .rst_flag      (rst_flag),
    .fuse_on_n     (fuse_on_n)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;
    localparam int MAXC       = 9;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       irq_ack = 1'b0;
    logic       rst_flag = 1'b0;
    logic       fuse_on_n = 1'b1;
    logic       irq;
    logic       sys_rst_pulse;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.BASE_LOG2(BASE), .MAX_CODE(MAXC), .WIN_CYC(4)) dut_i (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .kick(kick), .irq_ack(irq_ack), .rst_flag(rst_flag),
        .fuse_on_n(fuse_on_n), .irq(irq), .sys_rst_pulse(sys_rst_pulse)
    );

    function automatic int limit_of(input int code);
        return 1 << (BASE + ((code > MAXC) ? MAXC : code));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1;
        wr_data = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] b);
        irq_ack = 1'b1;
        kick = 1'b1;
        step();
        irq_ack = 1'b0;
        kick = 1'b0;
        wr(8'h18);
        wr(b);
    endtask

    // counts edges to the event (flag or reset pulse); tick_en low for gap cycles
    task automatic measure(input bit do_kick, input bit use_flag, input int gap,
                           input int exp, input string tag, output bit saw_rst);
        int  n = 0;
        bit  seen = 0;
        saw_rst = 0;
        if (do_kick) begin
            kick = 1'b1;
            step();
            kick = 1'b0;
        end
        while (!seen && n < exp + 40) begin
            tick_en = !(n >= 4 && n < 4 + gap);
            step();
            n++;
            if (sys_rst_pulse) saw_rst = 1;
            seen = use_flag ? rd_data[7] : sys_rst_pulse;
        end
        tick_en = 1'b1;
        check(tag, n, exp);
    endtask

    task automatic t_reset;
        bit any = 0;
        check("R1 reset byte", rd_data, 8'h00);
        check("R1 reset irq", irq, 0);
        check("R1 reset pulse", sys_rst_pulse, 0);
        for (int i = 0; i < 100; i++) begin
            step();
            if (sys_rst_pulse || rd_data[7]) any = 1;
        end
        check("R3 stopped mode no time-out", any, 0);
    endtask

    task automatic t_int_mode;
        bit r;
        set_cfg(8'h40);
        check("R2 byte readback int", rd_data, 8'h40);
        measure(1, 1, 0, limit_of(0), "R10 int period", r);
        check("R10 irq raised", irq, 1);
        check("R3 int mode no reset", r, 0);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check("R10 ack keeps ie", rd_data, 8'h40);
        check("R10 irq dropped", irq, 0);
    endtask

    task automatic t_reset_mode;
        bit r;
        set_cfg(8'h08);
        check("R3 reset mode byte", rd_data, 8'h08);
        measure(1, 0, 0, limit_of(0), "R6 reset period", r);
        step();
        check("R6 pulse one cycle", sys_rst_pulse, 0);
        wr(8'h00);
        check("R8 re not cleared outside window", rd_data, 8'h08);
        wr(8'h0B);
        check("R8 sel unchanged outside window", rd_data, 8'h08);
        wr(8'h88);
        check("R2 flag not writable", rd_data, 8'h08);
    endtask

    task automatic t_window;
        bit r;
        wr(8'h18);
        check("R7 window open", rd_data, 8'h18);
        step(); check("R7 unlock c2", rd_data[4], 1);
        step(); check("R7 unlock c3", rd_data[4], 1);
        step(); check("R7 unlock c4", rd_data[4], 1);
        step(); check("R7 unlock cleared", rd_data[4], 0);
        wr(8'h18);
        step(); step(); step();
        wr(8'h0A);
        check("R7 last-cycle write accepted", rd_data, 8'h0A);
        wr(8'h18);
        step(); step(); step(); step();
        wr(8'h09);
        check("R8 late write refused", rd_data, 8'h0A);
        measure(1, 0, 0, limit_of(2), "R5 code 2 period", r);
    endtask

    task automatic t_presc;
        bit r;
        set_cfg(8'h29);
        check("R2 select msb in bit5", rd_data, 8'h29);
        measure(1, 0, 0, limit_of(9), "R5 code 9 period", r);
        set_cfg(8'h2F);
        measure(1, 0, 0, limit_of(15), "R5 reserved code clamps", r);
        set_cfg(8'h09);
        measure(1, 0, 10, limit_of(1) + 10, "R5 idle ticks not counted", r);
    endtask

    task automatic t_both;
        bit r;
        set_cfg(8'h48);
        measure(1, 1, 0, limit_of(0), "R11 first time-out flags", r);
        check("R11 no reset on first", r, 0);
        check("R11 irq raised", irq, 1);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        check("R11 ack clears flag and ie", rd_data, 8'h08);
        check("R11 irq dropped", irq, 0);
        measure(1, 0, 0, limit_of(0), "R11 reset after ack", r);
        set_cfg(8'h48);
        measure(1, 1, 0, limit_of(0), "R11 flag again", r);
        measure(0, 0, 0, limit_of(0), "R11 reset while pending", r);
    endtask

    task automatic t_fuse;
        bit r;
        set_cfg(8'h40);
        fuse_on_n = 1'b0;
        measure(1, 0, 0, limit_of(0), "R4 fuse forces reset", r);
        check("R4 no flag under fuse", rd_data[7], 0);
        check("R4 no irq under fuse", irq, 0);
        fuse_on_n = 1'b1;
    endtask

    task automatic t_rst_flag;
        set_cfg(8'h00);
        check("R9 baseline re clear", rd_data, 8'h00);
        rst_flag = 1'b1;
        step();
        check("R9 pin forces re", rd_data[3], 1);
        wr(8'h18);
        wr(8'h00);
        check("R9 window cannot clear re", rd_data[3], 1);
        rst_flag = 1'b0;
        step();
        check("R9 re held after pin falls", rd_data[3], 1);
        set_cfg(8'h00);
        check("R9 re cleared via window", rd_data[3], 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired: got hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_int_mode();
        t_reset_mode();
        t_window();
        t_presc();
        t_both();
        t_fuse();
        t_rst_flag();
        finish_run();
    end
endmodule